// File: doc/BRIEF.md
# Coalesced Line Request Builder

This block folds a burst of narrow memory accesses that all fall in one cache line into a single line-wide request. Members arrive one per cycle with a kind (read, write, atomic or instruction fetch), a byte address, a byte count, up to eight bytes of write data, an atomic opcode and a flag that marks the final member of the group. While members arrive, the block accumulates a per-byte access mask, a line-sized data image and an ordered list of atomic operations.

The cycle after the final member is taken, the block presents the finished request for exactly one cycle. The request carries the aligned line address, a sequence tag, the mask, the merged data, the atomic list with its fill count, and two error flags. It then clears all accumulated state for the next group. The block has three named states. IDLE waits for the first member. MERGE takes the remaining members. EMIT presents the result. The transitions are: IDLE to MERGE on a non-final member, IDLE to EMIT on a final member, MERGE to EMIT on a final member, and EMIT to IDLE unconditionally.

Top module: `lcb_line_builder`

## Requirements
- R1: The output line address is the first member's address with its low 6 bits cleared. The output sequence tag is the first member's `in_seq`. Later members supply only their low 6 address bits as the byte offset.
- R2: Kinds are encoded as 0 read, 1 write, 2 atomic, 3 instruction fetch. For each read, write or atomic member, mask bits offset through offset+size-1 are set, with mask bit k standing for line byte k. A size of 0 marks no byte, a size above 8 counts as 8, and bytes beyond line byte 63 are discarded.
- R3: A write member copies its data byte j (`in_data[8j+7:8j]`) to line byte offset+j (`out_data[8k+7:8k]` for byte k). Line bytes that no write touched read as zero.
- R4: When writes overlap, the member that arrived later supplies the byte.
- R5: Each atomic member appends its offset and opcode to the list without touching data. Entry i sits in `out_atom_offs[6i+5:6i]` and `out_atom_ops[4i+3:4i]` in arrival order, and `out_atom_count` gives the number of entries.
- R6: The list holds 16 entries. Further atomic members are dropped and raise `out_err_ovf`, which leaves the mask still marked for their bytes.
- R7: An instruction-fetch member raises `out_err_ifetch` and changes neither mask nor data.
- R8: `out_valid` is high for exactly one cycle, the cycle after the clock edge that took a member with `in_last` set, and it is low at every other time.
- R9: A member presented while `out_valid` is high is dropped and has no effect on any later request.
- R10: After a request is presented, the next group starts from an all-zero mask, data image and list, with both flags clear.
- R11: During and after reset, `out_valid`, `out_mask`, `out_atom_count` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A member is presented this cycle |
| in_kind | input | 2 | Member kind: 0 read, 1 write, 2 atomic, 3 fetch |
| in_addr | input | 32 | Member byte address |
| in_size | input | 4 | Member byte count |
| in_data | input | 64 | Write data, byte j at bits 8j+7:8j |
| in_op | input | 4 | Atomic opcode |
| in_last | input | 1 | Final member of the group |
| in_seq | input | 8 | Sequence tag, taken from the first member |
| out_valid | output | 1 | Built request present (one cycle) |
| out_line_addr | output | 32 | Aligned line address |
| out_seq | output | 8 | Sequence tag |
| out_mask | output | 64 | Per-byte access mask |
| out_data | output | 512 | Merged line data |
| out_atom_count | output | 5 | Number of atomic list entries |
| out_atom_offs | output | 96 | Atomic entry offsets, 6 bits each |
| out_atom_ops | output | 64 | Atomic entry opcodes, 4 bits each |
| out_err_ifetch | output | 1 | A fetch member was seen in the group |
| out_err_ovf | output | 1 | The atomic list overflowed |

## Verification
A stuck state register would show at the ports as a missing or doubled `out_valid` pulse, or as members being dropped, no later than the group's final member. Stale accumulation left from a previous group would surface as extra mask bits, nonzero data or a nonzero count in the very next request. Corrupted offsets or byte lanes would appear as misplaced data bytes when that same group is presented. Comparing every field on every presented request, against a model that starts clean for each group, exposes any of these within one group.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

    typedef enum logic [1:0] {
        KIND_READ   = 2'd0,
        KIND_WRITE  = 2'd1,
        KIND_ATOMIC = 2'd2,
        KIND_IFETCH = 2'd3
    } member_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_EMIT  = 2'd2
    } build_state_e;

endpackage

// File: rtl/lcb_byte_span.sv
// Marks the line bytes covered by one member: offset .. offset+size-1,
// size clamped to MAX_BYTES, nothing past the last line byte.
module lcb_byte_span #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 8,
    parameter int SIZE_W     = 4,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [OFF_W-1:0]      offset,
    input  logic [SIZE_W-1:0]     size,
    output logic [LINE_BYTES-1:0] span
);

    logic [SIZE_W-1:0] eff_size;

    assign eff_size = (size > SIZE_W'(MAX_BYTES)) ? SIZE_W'(MAX_BYTES) : size;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        localparam int BI = b;
        assign span[b] = (BI >= int'(offset)) &&
                         ((BI - int'(offset)) < int'(eff_size));
    end

endmodule

// File: rtl/lcb_byte_place.sv
// Rotates member data so that its byte j lands on line byte offset+j.
// Only the bytes flagged by the span are ever used downstream.
module lcb_byte_place #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 8,
    localparam int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic [IDX_W-1:0]        low_off,
    input  logic [MAX_BYTES*8-1:0]  data,
    output logic [LINE_BYTES*8-1:0] line
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx = IDX_W'(b) - low_off;
        assign line[b*8 +: 8] = data[{idx, 3'b000} +: 8];
    end

endmodule

// File: rtl/lcb_atom_list.sv
// Ordered list of atomic (offset, opcode) entries with a fill counter.
module lcb_atom_list #(
    parameter int DEPTH = 16,
    parameter int OFF_W = 6,
    parameter int OP_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [OFF_W-1:0]   push_off,
    input  logic [OP_W-1:0]    push_op,
    output logic [CNT_W-1:0]   count,
    output logic               full,
    output logic [DEPTH*OFF_W-1:0] offs,
    output logic [DEPTH*OP_W-1:0]  ops
);

    logic [CNT_W-1:0] count_q;

    assign count = count_q;
    assign full  = (count_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count_q <= '0;
        end else if (push && !full) begin
            count_q <= count_q + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [OFF_W-1:0] off_q;
        logic [OP_W-1:0]  op_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                off_q <= '0;
                op_q  <= '0;
            end else if (push && !full && (count_q == CNT_W'(i))) begin
                off_q <= push_off;
                op_q  <= push_op;
            end
        end

        assign offs[i*OFF_W +: OFF_W] = off_q;
        assign ops[i*OP_W +: OP_W]    = op_q;
    end

endmodule

// File: rtl/lcb_line_builder.sv
module lcb_line_builder
    import lcb_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int MAX_BYTES  = 8,
    parameter int SIZE_W     = 4,
    parameter int ATOM_DEPTH = 16,
    parameter int OP_W       = 4,
    parameter int SEQ_W      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(MAX_BYTES),
    localparam int CNT_W     = $clog2(ATOM_DEPTH + 1),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                in_kind,
    input  logic [ADDR_W-1:0]         in_addr,
    input  logic [SIZE_W-1:0]         in_size,
    input  logic [MAX_BYTES*8-1:0]    in_data,
    input  logic [OP_W-1:0]           in_op,
    input  logic                      in_last,
    input  logic [SEQ_W-1:0]          in_seq,
    output logic                      out_valid,
    output logic [ADDR_W-1:0]         out_line_addr,
    output logic [SEQ_W-1:0]          out_seq,
    output logic [LINE_BYTES-1:0]     out_mask,
    output logic [LINE_BITS-1:0]      out_data,
    output logic [CNT_W-1:0]          out_atom_count,
    output logic [ATOM_DEPTH*OFF_W-1:0] out_atom_offs,
    output logic [ATOM_DEPTH*OP_W-1:0]  out_atom_ops,
    output logic                      out_err_ifetch,
    output logic                      out_err_ovf
);

    build_state_e state_q, state_d;
    member_kind_e kind;

    logic                  accept;
    logic                  first_mem;
    logic                  clear_acc;
    logic [OFF_W-1:0]      mem_off;
    logic [LINE_BYTES-1:0] span;
    logic [LINE_BYTES-1:0] mask_add;
    logic [LINE_BITS-1:0]  placed;
    logic [LINE_BITS-1:0]  lane_en;
    logic                  atom_push;
    logic                  atom_full;

    logic [ADDR_W-1:0]     line_q;
    logic [SEQ_W-1:0]      seq_q;
    logic [LINE_BYTES-1:0] mask_q;
    logic [LINE_BITS-1:0]  data_q;
    logic                  ifetch_q;
    logic                  ovf_q;

    assign kind      = member_kind_e'(in_kind);
    assign accept    = in_valid && (state_q != ST_EMIT);
    assign first_mem = (state_q == ST_IDLE);
    assign clear_acc = (state_q == ST_EMIT);
    assign mem_off   = in_addr[OFF_W-1:0];
    assign mask_add  = (kind == KIND_IFETCH) ? '0 : span;
    assign atom_push = accept && (kind == KIND_ATOMIC);

    lcb_byte_span #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_BYTES  (MAX_BYTES),
        .SIZE_W     (SIZE_W)
    ) u_span (
        .offset (mem_off),
        .size   (in_size),
        .span   (span)
    );

    lcb_byte_place #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_BYTES  (MAX_BYTES)
    ) u_place (
        .low_off (in_addr[IDX_W-1:0]),
        .data    (in_data),
        .line    (placed)
    );

    lcb_atom_list #(
        .DEPTH (ATOM_DEPTH),
        .OFF_W (OFF_W),
        .OP_W  (OP_W)
    ) u_atoms (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_acc),
        .push     (atom_push),
        .push_off (mem_off),
        .push_op  (in_op),
        .count    (out_atom_count),
        .full     (atom_full),
        .offs     (out_atom_offs),
        .ops      (out_atom_ops)
    );

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane_en
        assign lane_en[b*8 +: 8] = {8{span[b]}};
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = in_last ? ST_EMIT : ST_MERGE;
                end
            end
            ST_MERGE: begin
                if (in_valid && in_last) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_acc) begin
            line_q   <= '0;
            seq_q    <= '0;
            mask_q   <= '0;
            data_q   <= '0;
            ifetch_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else if (accept) begin
            if (first_mem) begin
                line_q <= {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                seq_q  <= in_seq;
            end
            mask_q <= mask_q | mask_add;
            if (kind == KIND_WRITE) begin
                data_q <= (data_q & ~lane_en) | (placed & lane_en);
            end
            if (kind == KIND_IFETCH) begin
                ifetch_q <= 1'b1;
            end
            if (atom_push && atom_full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        out_valid      = (state_q == ST_EMIT);
        out_line_addr  = line_q;
        out_seq        = seq_q;
        out_mask       = mask_q;
        out_data       = data_q;
        out_err_ifetch = ifetch_q;
        out_err_ovf    = ovf_q;
    end

endmodule

// File: rtl/lcb_line_builder_chk.sv
module lcb_line_builder_chk #(
    parameter int OFF_W      = 6,
    parameter int ATOM_DEPTH = 16,
    localparam int CNT_W     = $clog2(ATOM_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic             in_last,
    input logic             out_valid,
    input logic [OFF_W-1:0] line_low,
    input logic [CNT_W-1:0] atom_count,
    input logic             err_ifetch,
    input logic             err_ovf
);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_follows_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));

    assert_last_emits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && !out_valid) |=> out_valid);

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (line_low == '0));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        atom_count <= CNT_W'(ATOM_DEPTH));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_ovf) |-> (atom_count == CNT_W'(ATOM_DEPTH)));

    assert_fetch_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd3 && in_last && !out_valid) |=> err_ifetch);

endmodule

bind lcb_line_builder lcb_line_builder_chk #(
    .OFF_W      (OFF_W),
    .ATOM_DEPTH (ATOM_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .line_low   (out_line_addr[OFF_W-1:0]),
    .atom_count (out_atom_count),
    .err_ifetch (out_err_ifetch),
    .err_ovf    (out_err_ovf)
);

// File: tb/lcb_line_builder_tb.sv
`timescale 1ns/1ps
module lcb_line_builder_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_kind = '0;
    logic [31:0]  in_addr = '0;
    logic [3:0]   in_size = '0;
    logic [63:0]  in_data = '0;
    logic [3:0]   in_op = '0;
    logic         in_last = 1'b0;
    logic [7:0]   in_seq = '0;
    logic         out_valid;
    logic [31:0]  out_line_addr;
    logic [7:0]   out_seq;
    logic [63:0]  out_mask;
    logic [511:0] out_data;
    logic [4:0]   out_atom_count;
    logic [95:0]  out_atom_offs;
    logic [63:0]  out_atom_ops;
    logic         out_err_ifetch;
    logic         out_err_ovf;

    int checks = 0;
    int failures = 0;

    // Reference model state.
    logic [63:0]  m_mask;
    logic [511:0] m_data;
    logic [5:0]   m_aoff [16];
    logic [3:0]   m_aop  [16];
    int           m_cnt;
    logic         m_ifetch, m_ovf, m_first;
    logic [31:0]  m_line;
    logic [7:0]   m_seq;

    always #4 clk = ~clk;

    lcb_line_builder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_addr(in_addr), .in_size(in_size), .in_data(in_data), .in_op(in_op),
        .in_last(in_last), .in_seq(in_seq), .out_valid(out_valid),
        .out_line_addr(out_line_addr), .out_seq(out_seq), .out_mask(out_mask),
        .out_data(out_data), .out_atom_count(out_atom_count),
        .out_atom_offs(out_atom_offs), .out_atom_ops(out_atom_ops),
        .out_err_ifetch(out_err_ifetch), .out_err_ovf(out_err_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_mask = '0; m_data = '0; m_cnt = 0;
        m_ifetch = 1'b0; m_ovf = 1'b0; m_first = 1'b1;
        m_line = '0; m_seq = '0;
        for (int i = 0; i < 16; i++) begin
            m_aoff[i] = '0; m_aop[i] = '0;
        end
    endtask

    task automatic model_apply(input int kind, input logic [31:0] addr,
                               input int size, input logic [63:0] data,
                               input logic [3:0] op, input logic [7:0] seq);
        int off, eff;
        if (m_first) begin
            m_line = {addr[31:6], 6'd0};
            m_seq = seq;
            m_first = 1'b0;
        end
        off = int'(addr[5:0]);
        eff = (size > 8) ? 8 : size;
        if (kind == 3) begin
            m_ifetch = 1'b1;
        end else begin
            for (int j = 0; j < eff; j++) begin
                if (off + j < 64) begin
                    m_mask[off + j] = 1'b1;
                    if (kind == 1) m_data[(off + j) * 8 +: 8] = data[j * 8 +: 8];
                end
            end
            if (kind == 2) begin
                if (m_cnt < 16) begin
                    m_aoff[m_cnt] = addr[5:0];
                    m_aop[m_cnt] = op;
                    m_cnt++;
                end else begin
                    m_ovf = 1'b1;
                end
            end
        end
    endtask

    // Presents one member from a negedge and returns at the following negedge.
    task automatic send(input int kind, input logic [31:0] addr, input int size,
                        input logic [63:0] data, input logic [3:0] op,
                        input bit last, input logic [7:0] seq);
        in_valid = 1'b1; in_kind = 2'(kind); in_addr = addr; in_size = 4'(size);
        in_data = data; in_op = op; in_last = last; in_seq = seq;
        model_apply(kind, addr, size, data, op, seq);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (!last) check(out_valid == 1'b0, "R8", "valid while merging", 512'(out_valid), 512'(0));
    endtask

    // Called at the negedge after the final member; leaves at the next negedge.
    task automatic check_emit(input bit drop_member);
        check(out_valid == 1'b1, "R8", "valid after last", 512'(out_valid), 512'(1));
        check(out_line_addr == m_line, "R1", "line address", 512'(out_line_addr), 512'(m_line));
        check(out_seq == m_seq, "R1", "sequence tag", 512'(out_seq), 512'(m_seq));
        check(out_mask == m_mask, "R2", "mask", 512'(out_mask), 512'(m_mask));
        check(out_data == m_data, "R3", "data", out_data, m_data);
        check(int'(out_atom_count) == m_cnt, "R5", "atomic count", 512'(out_atom_count), 512'(m_cnt));
        for (int i = 0; i < 16; i++) begin
            if (i < m_cnt) begin
                check(out_atom_offs[i*6 +: 6] == m_aoff[i] && out_atom_ops[i*4 +: 4] == m_aop[i],
                      "R5", "atomic entry", 512'({out_atom_offs[i*6 +: 6], out_atom_ops[i*4 +: 4]}),
                      512'({m_aoff[i], m_aop[i]}));
            end
        end
        check(out_err_ovf == m_ovf, "R6", "overflow flag", 512'(out_err_ovf), 512'(m_ovf));
        check(out_err_ifetch == m_ifetch, "R7", "fetch flag", 512'(out_err_ifetch), 512'(m_ifetch));
        if (drop_member) begin
            // R9: this member lands while out_valid is high and must be ignored.
            in_valid = 1'b1; in_kind = 2'd1; in_addr = 32'h0000_1000; in_size = 4'd8;
            in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_op = 4'hF; in_last = 1'b1; in_seq = 8'hEE;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check(out_valid == 1'b0, "R8", "single cycle pulse", 512'(out_valid), 512'(1'b0));
        model_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] base;
        void'($urandom(32'd20250));
        model_clear();
        repeat (3) @(negedge clk);
        // R11: reset state.
        check(out_valid == 1'b0 && out_mask == '0 && out_atom_count == '0 &&
              !out_err_ifetch && !out_err_ovf, "R11", "reset outputs",
              512'({out_valid, out_mask, out_atom_count}), 512'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R11", "idle after reset", 512'(out_valid), 512'(0));

        // R4: overlapping writes, later wins; R3 zero elsewhere.
        send(1, 32'h0000_4010, 8, 64'h1111_1111_1111_1111, 0, 0, 8'h01);
        send(1, 32'h0000_4014, 8, 64'h2222_2222_2222_2222, 0, 1, 8'h99);
        check(out_data[20*8 +: 8] == 8'h22, "R4", "later write wins",
              512'(out_data[20*8 +: 8]), 512'(8'h22));
        check_emit(0);

        // R2: clipping at line end, size 0, size above 8.
        send(1, 32'h0000_807E, 8, 64'h8877_6655_4433_2211, 0, 0, 8'h02);
        send(0, 32'h0000_8000, 0, 64'h0, 0, 0, 8'h00);
        send(0, 32'h0000_8010, 12, 64'h0, 0, 1, 8'h00);
        check(out_mask == 64'hC000_0000_00FF_0000, "R2", "clip and clamp",
              512'(out_mask), 512'(64'hC000_0000_00FF_0000));
        check_emit(0);

        // R6: seventeen atomics.
        for (int i = 0; i < 17; i++)
            send(2, 32'h0001_0000 + 32'(i * 3), 2, 64'hABCD, 4'(i), (i == 16), 8'h03);
        check_emit(0);

        // R7: fetch member, then R9 drop during emit, then R10 clean start.
        send(1, 32'h0002_0008, 4, 64'hDEAD_BEEF, 0, 0, 8'h04);
        send(3, 32'h0002_0020, 8, 64'hFFFF_FFFF, 0, 1, 8'h00);
        check_emit(1);
        send(0, 32'h0003_0004, 1, 64'h0, 0, 1, 8'h05);
        check(out_data == '0 && out_mask == 64'h10 && !out_err_ifetch, "R9",
              "dropped member left no trace", 512'(out_mask), 512'(64'h10));
        check(out_line_addr == 32'h0003_0000, "R10", "fresh line",
              512'(out_line_addr), 512'(32'h0003_0000));
        check_emit(0);

        // Random groups.
        for (int g = 0; g < 60; g++) begin
            int n;
            n = 1 + int'($urandom_range(0, 7));
            base = {$urandom, 6'd0} & 32'hFFFF_FFC0;
            for (int k = 0; k < n; k++) begin
                int kind;
                kind = int'($urandom_range(0, 9));
                kind = (kind < 2) ? 0 : (kind < 7) ? 1 : (kind < 9) ? 2 : 3;
                send(kind, base | 32'($urandom_range(0, 63)), int'($urandom_range(0, 9)),
                     {$urandom, $urandom}, 4'($urandom), (k == n - 1), 8'($urandom));
            end
            check_emit(g % 5 == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule